// File: doc/BRIEF.md
# Wrapped Memory Map Address Decoder

This block turns a 32-bit CPU data address into a one-hot region select for a microcontroller bus. It also gives a byte offset inside the selected region. The regions are on-chip ROM, internal RAM, the peripheral I/O page, external memory, and a reserved page that must never be touched. Region decoding is purely combinational, so a select is valid in the same cycle as the address.

With the wrap strap high, only the low 28 address bits are decoded. The 256 MB map then repeats 16 times across the 4 GB space. Internal RAM can be reached through two windows: one sits directly below the I/O page and the other directly below the reserved page near 64 MB. Both windows give the same offsets, so they address one physical array. Static straps choose the RAM size, disable the ROM, or move the ROM up by 1 MB.

An access to the reserved page selects nothing. It raises a registered fault pulse on the following cycle, together with the read/write direction of the offending access.

Top module: `addr_alias_decoder`

## Requirements
- R1: With `cfg_wrap` high, address bits 31..28 have no effect on selects, offset or fault. The decoded address is the low 28 bits.
- R2: Decoded addresses 0xFFFF000..0xFFFFFFF assert `sel_io`, and `off` equals the address minus 0xFFFF000.
- R3: RAM window A spans [0xFFFF000-S, 0xFFFF000), where S = 2^(13+`cfg_ram_sz`) - 4096 bytes: 4, 12, 28 or 60 KB for codes 0..3. In that window `sel_ram` is asserted and `off` = address - (0xFFFF000-S).
- R4: RAM window B spans [0x3FFF000-S, 0x3FFF000) and asserts `sel_ram`, with `off` = address - (0x3FFF000-S). Corresponding addresses in windows A and B therefore give equal offsets.
- R5: A valid access to 0x3FFF000..0x3FFFFFF asserts no select and drives `off` to 0. `fault` is high for exactly the next cycle, and `fault_wr` then holds the `acc_write` value of that access. Otherwise `fault` stays low.
- R6: With `cfg_rom_en` high and `cfg_rom_hi` low, addresses 0x0000000..0x00FFFFF assert `sel_rom` with `off` equal to the address.
- R7: With `cfg_rom_en` and `cfg_rom_hi` high, ROM covers 0x0100000..0x01FFFFF with `off` = address - 0x100000, and 0x0000000..0x00FFFFF decodes as external memory.
- R8: With `cfg_rom_en` low, the ROM span decodes as external memory.
- R9: Any valid address that falls in no other region asserts `sel_ext`, with `off` equal to the full decoded address.
- R10: With `cfg_wrap` low, all 32 bits are decoded, and every address of 0x10000000 or above asserts `sel_ext` with `off` equal to the address.
- R11: With `acc_valid` low, no select and no fault is produced and `off` is 0. With it high, at most one select is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Address strobe |
| acc_addr | input | 32 | CPU data address |
| acc_write | input | 1 | 1 = write, 0 = read |
| cfg_wrap | input | 1 | Strap: decode only the low 28 bits |
| cfg_rom_en | input | 1 | Strap: ROM present |
| cfg_rom_hi | input | 1 | Strap: ROM moved to the second megabyte |
| cfg_ram_sz | input | 2 | Strap: RAM size code (4/12/28/60 KB) |
| sel_rom | output | 1 | ROM selected |
| sel_ram | output | 1 | Internal RAM selected (either window) |
| sel_io | output | 1 | Peripheral I/O page selected |
| sel_ext | output | 1 | External memory selected |
| off | output | 32 | Byte offset inside the selected region |
| fault | output | 1 | One-cycle pulse after a reserved-page access |
| fault_wr | output | 1 | Direction of the access that caused the fault |

## Verification
The bench sweeps the edges of every window for each RAM size code and every strap combination, both with non-zero and with zero upper address nibbles. A size computed off by one page would misplace the lower RAM edge, so the first RAM address would come out external or the last external address would come out as RAM. A wrong second window base would make offsets in window B differ from those in window A. A reserved-page decode that also fell through to external memory would assert `sel_ext` together with the fault. A fault taken combinationally, or held for more than one cycle, would be caught by the cycle-exact comparison. With wrap disabled, a decoder that still masks the top nibble would alias high addresses into RAM or I/O, and the bench would see that.

// File: rtl/addr_alias_decoder.sv
module addr_alias_decoder #(
  parameter int AW        = 32,
  parameter int WRAP_BITS = 28,
  parameter int PAGE_BITS = 12,
  parameter int ROM_BITS  = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_valid,
  input  logic [AW-1:0] acc_addr,
  input  logic          acc_write,
  input  logic          cfg_wrap,
  input  logic          cfg_rom_en,
  input  logic          cfg_rom_hi,
  input  logic [1:0]    cfg_ram_sz,
  output logic          sel_rom,
  output logic          sel_ram,
  output logic          sel_io,
  output logic          sel_ext,
  output logic [AW-1:0] off,
  output logic          fault,
  output logic          fault_wr
);
  localparam int WB = WRAP_BITS;
  localparam logic [WB-1:0] PAGE     = WB'(1) << PAGE_BITS;
  localparam logic [WB-1:0] IO_BASE  = {WB{1'b1}} - PAGE + WB'(1);
  localparam logic [WB-1:0] GAP_BASE = (WB'(1) << 26) - PAGE;
  localparam logic [WB-1:0] ROM_SPAN = WB'(1) << ROM_BITS;

  logic [AW-1:0] eff;
  logic [WB-1:0] a, ram_sz, ram_a_base, ram_b_base, rom_base;
  logic          hi_ext, hit_io, hit_gap, hit_ram_a, hit_ram_b, hit_rom, hit_any;

  assign eff    = cfg_wrap ? {{(AW-WB){1'b0}}, acc_addr[WB-1:0]} : acc_addr;
  assign hi_ext = |eff[AW-1:WB];
  assign a      = eff[WB-1:0];

  assign ram_sz     = (WB'(1) << (PAGE_BITS + 1 + int'(cfg_ram_sz))) - PAGE;
  assign ram_a_base = IO_BASE - ram_sz;
  assign ram_b_base = GAP_BASE - ram_sz;
  assign rom_base   = cfg_rom_hi ? ROM_SPAN : '0;

  assign hit_io    = !hi_ext && a >= IO_BASE;
  assign hit_gap   = !hi_ext && a[WB-1:PAGE_BITS] == GAP_BASE[WB-1:PAGE_BITS];
  assign hit_ram_a = !hi_ext && a >= ram_a_base && a < IO_BASE;
  assign hit_ram_b = !hi_ext && a >= ram_b_base && a < GAP_BASE;
  assign hit_rom   = !hi_ext && cfg_rom_en &&
                     a[WB-1:ROM_BITS] == rom_base[WB-1:ROM_BITS];
  assign hit_any   = hit_io | hit_gap | hit_ram_a | hit_ram_b | hit_rom;

  assign sel_io  = acc_valid && hit_io;
  assign sel_ram = acc_valid && (hit_ram_a || hit_ram_b);
  assign sel_rom = acc_valid && hit_rom;
  assign sel_ext = acc_valid && !hit_any;

  always_comb begin
    off = '0;
    if (sel_io)
      off = {{(AW-WB){1'b0}}, a - IO_BASE};
    else if (sel_ram)
      off = {{(AW-WB){1'b0}}, a - (hit_ram_a ? ram_a_base : ram_b_base)};
    else if (sel_rom)
      off = {{(AW-WB){1'b0}}, a - rom_base};
    else if (sel_ext)
      off = eff;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault    <= 1'b0;
      fault_wr <= 1'b0;
    end else begin
      fault    <= acc_valid && hit_gap;
      fault_wr <= acc_valid && hit_gap && acc_write;
    end
  end
endmodule

// File: rtl/addr_alias_decoder_chk.sv
module addr_alias_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        acc_valid,
  input logic [31:0] acc_addr,
  input logic        acc_write,
  input logic        cfg_wrap,
  input logic        sel_rom,
  input logic        sel_ram,
  input logic        sel_io,
  input logic        sel_ext,
  input logic [31:0] off,
  input logic        fault,
  input logic        fault_wr
);
  logic gap_port, io_port;
  assign gap_port = cfg_wrap ? (acc_addr[27:12] == 16'h3FFF) : (acc_addr[31:12] == 20'h03FFF);
  assign io_port  = cfg_wrap ? (acc_addr[27:12] == 16'hFFFF) : (acc_addr[31:12] == 20'h0FFFF);

  p_onehot_sel_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_rom, sel_ram, sel_io, sel_ext}));
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> !(sel_rom || sel_ram || sel_io || sel_ext) && off == 32'h0);
  p_gap_nosel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && gap_port |-> !(sel_rom || sel_ram || sel_io || sel_ext));
  p_gap_fault_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && gap_port |=> fault && fault_wr == $past(acc_write));
  p_fault_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_valid && gap_port) |=> !fault);
  p_io_page_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && io_port |-> sel_io && off[31:12] == 20'h0);
  p_ram_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sel_ram |-> off < 32'h10000);
endmodule

bind addr_alias_decoder addr_alias_decoder_chk u_chk (.*);

// File: tb/sim_addr_alias_decoder.sv
`timescale 1ns/1ps
module sim_addr_alias_decoder;
  logic clk = 0, rst_n = 0;
  logic acc_valid = 0, acc_write = 0, cfg_wrap = 1, cfg_rom_en = 1, cfg_rom_hi = 0;
  logic [31:0] acc_addr = 0;
  logic [1:0] cfg_ram_sz = 0;
  logic sel_rom, sel_ram, sel_io, sel_ext, fault, fault_wr;
  logic [31:0] off;
  int checks = 0, fails = 0;
  logic exp_fault = 0, exp_fwr = 0;
  bit running = 0;

  always #5 clk = ~clk;

  addr_alias_decoder u0 (.*);

  // region: 0 none, 1 rom, 2 ram, 3 io, 4 ext, 5 reserved
  task automatic model(output int reg_o, output longint off_o, output string tag);
    longint e, sz, ba, bb, rb;
    e = cfg_wrap ? longint'(acc_addr[27:0]) : longint'(acc_addr);
    sz = (longint'(1) << (13 + cfg_ram_sz)) - 4096;
    ba = 64'hFFFF000 - sz; bb = 64'h3FFF000 - sz;
    rb = cfg_rom_hi ? 64'h100000 : 0;
    off_o = 0;
    if (!acc_valid) begin reg_o = 0; tag = "R11"; end
    else if (e >= 64'h10000000) begin reg_o = 4; off_o = e; tag = "R10"; end
    else if (e >= 64'hFFFF000) begin reg_o = 3; off_o = e - 64'hFFFF000; tag = "R2"; end
    else if (e >= 64'h3FFF000 && e <= 64'h3FFFFFF) begin reg_o = 5; tag = "R5"; end
    else if (e >= ba && e < 64'hFFFF000) begin reg_o = 2; off_o = e - ba; tag = "R3"; end
    else if (e >= bb && e < 64'h3FFF000) begin reg_o = 2; off_o = e - bb; tag = "R4"; end
    else if (cfg_rom_en && e >= rb && e < rb + 64'h100000) begin
      reg_o = 1; off_o = e - rb; tag = cfg_rom_hi ? "R7" : "R6"; end
    else begin
      reg_o = 4; off_o = e;
      tag = (e < 64'h200000 && (!cfg_rom_en || cfg_rom_hi)) ? (cfg_rom_en ? "R7" : "R8") : "R9";
    end
    if (cfg_wrap && acc_addr[31:28] != 0) tag = {"R1/", tag};
  endtask

  always @(posedge clk) begin
    int r; longint o; string t;
    model(r, o, t);
    exp_fault <= rst_n && r == 5;
    exp_fwr   <= rst_n && r == 5 && acc_write;
  end

  always @(negedge clk) if (running) begin
    int r; longint o; string t;
    logic [3:0] es;
    model(r, o, t);
    es = {r == 1, r == 2, r == 3, r == 4};
    checks++;
    if ({sel_rom, sel_ram, sel_io, sel_ext} != es || off != o[31:0]) begin
      fails++;
      $display("FAIL %s addr=%h sel=%b off=%h expected sel=%b off=%h", t, acc_addr,
               {sel_rom, sel_ram, sel_io, sel_ext}, off, es, o[31:0]);
    end
    checks++;
    if (fault !== exp_fault || fault_wr !== exp_fwr) begin
      fails++;
      $display("FAIL R5 fault=%b fault_wr=%b expected %b %b", fault, fault_wr, exp_fault, exp_fwr);
    end
  end

  task automatic apply(input logic v, input logic [31:0] ad, input logic w);
    @(posedge clk); #2;
    acc_valid = v; acc_addr = ad; acc_write = w;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] pts [13];
    pts = '{32'h0, 32'hFFFFF, 32'h100000, 32'h1FFFFF, 32'h200000, 32'h3FEEFFF,
            32'h3FFEFFF, 32'h3FFF000, 32'h3FFFFFF, 32'h4000000, 32'hFFEF000,
            32'hFFFEFFF, 32'hFFFF000};
    repeat (3) @(posedge clk);
    // reset state
    checks++;
    if (fault !== 0 || fault_wr !== 0) begin
      fails++; $display("FAIL R5 reset fault=%b expected 0", fault);
    end
    #2 rst_n = 1; running = 1;
    // R11 idle strobe on reserved page and RAM
    apply(0, 32'h3FFF010, 1);
    apply(0, 32'hFFFE000, 0);
    // R5 back-to-back reserved accesses, then a clean one
    apply(1, 32'h3FFF000, 1);
    apply(1, 32'h3FFFFFC, 0);
    apply(1, 32'h0000100, 0);
    // R1 wrapped aliases of the reserved page and I/O page
    apply(1, 32'hA3FFF008, 1);
    apply(1, 32'h5FFFF123, 0);
    // sweep: R3 R4 R6 R7 R8 R9 R10 across all straps
    for (int wr = 0; wr < 2; wr++)
      for (int re = 0; re < 2; re++)
        for (int rh = 0; rh < 2; rh++)
          for (int sz = 0; sz < 4; sz++) begin
            @(posedge clk); #2;
            cfg_wrap = wr[0]; cfg_rom_en = re[0]; cfg_rom_hi = rh[0]; cfg_ram_sz = sz[1:0];
            for (int p = 0; p < 13; p++) begin
              longint s;
              s = (longint'(1) << (13 + sz)) - 4096;
              apply(1, pts[p], p[0]);
              apply(1, pts[p] | 32'h70000000, 0);
              apply(1, pts[p] | 32'hF0000000, 1);
              // R3 / R4 window edges for this size
              if (p == 0) begin
                apply(1, 32'hFFFF000 - 32'(s), 0);
                apply(1, 32'hFFFF000 - 32'(s) - 1, 0);
                apply(1, 32'h3FFF000 - 32'(s), 1);
                apply(1, 32'h3FFF000 - 32'(s) - 1, 0);
              end
            end
          end
    apply(0, 32'h0, 0);
    @(posedge clk); @(negedge clk); #1;
    running = 0;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule